// File: doc/BRIEF.md
# Edge-Timed Long Clock Delay

This block delays a slow square wave by a fixed, long interval: 300 cycles of a 100 MHz system clock in the default setting, which is 3 us. A plain sampling pipeline of that depth would cost one flop per cycle of delay. Instead, the input is first synchronized. Each transition then starts a countdown timer, with a separate timer for rising and for falling transitions. When a timer runs out, the output takes the level of the transition that started it. Each edge is reproduced to within one system-clock period using only two counters.

A falling transition that arrives while the rising delay is still running is kept and reproduced, so pulses shorter than the delay keep their width. A second transition of the same polarity that arrives while that polarity's timer is still busy cannot be held. The block flags it with a one-cycle overrun pulse and restarts the timer from the newer edge. A parameter selects a coarse comparison mode in its place. In that mode a short shift register samples the synchronized level once every DECIM cycles, and the timing accuracy is one sample interval.

Top module: `edge_delay_line`

## Requirements
- R1: While reset is held, and after it is released, `delayedOut` and `overrun` are 0. A transition still pending when reset is asserted is discarded: after release, with the input low, the output stays 0.
- R2: The first clock edge that samples the input high after a low level is edge k. In the default mode `delayedOut` goes high at edge k+DELAY_CYC (k+300), and not before.
- R3: The first clock edge that samples the input low after a high level is edge k. `delayedOut` goes low at edge k+DELAY_CYC.
- R4: Rising and falling transitions are timed independently. A falling transition arriving while the rising delay is pending is still reproduced, so a 5-cycle input pulse gives a 5-cycle output pulse.
- R5: Between reproduced transitions, `delayedOut` holds its value.
- R6: A transition of the same polarity may arrive while that polarity's timer is busy; its first sampling edge is k2. `overrun` is then 1 for exactly the cycle after edge k2+SYNC_STAGES. The earlier transition is dropped, and the output edge appears at k2+DELAY_CYC.
- R7: `overrun` stays 0 whenever same-polarity transitions are at least DELAY_CYC cycles apart.
- R8: With LOW_RES=1, each output edge lands between k+DELAY_CYC-DECIM+SYNC_STAGES and k+DELAY_CYC+SYNC_STAGES-1, and `overrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| asyncIn | input | 1 | Slow asynchronous square wave |
| delayedOut | output | 1 | Input delayed by DELAY_CYC cycles |
| overrun | output | 1 | One-cycle pulse when a pending same-polarity edge is replaced |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- An off-by-one in the synchronizer compensation shifts every output edge by a cycle. The per-cycle delay model catches this at once.
- A single shared timer would swallow the falling edge of a short pulse, and the output would stay high or lose its width.
- A timer that ignores a restart would reproduce the dropped first edge, or would fail to raise `overrun` in its exact cycle.
- A reset that leaves a timer armed would produce a phantom rising edge after release.
- In the coarse mode, a wrong tap count or sampling enable would move edges outside the one-interval window.

// File: rtl/edge_delay_pkg.sv
`timescale 1ns/1ps
package edge_delay_pkg;
  // Strobes passed from the edge-detect control to the timing datapath
  typedef struct packed {
    logic riseStart;
    logic fallStart;
    logic level;
  } edgeStrb_t;
endpackage

// File: rtl/edge_delay_ctrl.sv
`timescale 1ns/1ps
module edge_delay_ctrl
  import edge_delay_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      asyncIn,
  output edgeStrb_t strb
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   lastLvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain   <= '0;
      lastLvl <= 1'b0;
    end else begin
      chain   <= {chain[SYNC_STAGES-2:0], asyncIn};
      lastLvl <= chain[SYNC_STAGES-1];
    end
  end

  always_comb begin
    strb.level     = chain[SYNC_STAGES-1];
    strb.riseStart = chain[SYNC_STAGES-1] & ~lastLvl;
    strb.fallStart = ~chain[SYNC_STAGES-1] & lastLvl;
  end
endmodule

// File: rtl/edge_timer.sv
`timescale 1ns/1ps
module edge_timer #(
  parameter int LOAD  = 298,
  parameter int CNT_W = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active,
  output logic expire,
  output logic restart
);
  logic [CNT_W-1:0] cnt;

  assign expire  = active && (cnt == CNT_W'(1));
  assign restart = start && active && !expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= CNT_W'(LOAD);
    end else if (active) begin
      if (cnt == CNT_W'(1)) active <= 1'b0;
      else                  cnt    <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/edge_delay_dp.sv
`timescale 1ns/1ps
module edge_delay_dp
  import edge_delay_pkg::*;
#(
  parameter int DELAY_CYC   = 300,
  parameter int SYNC_STAGES = 2,
  parameter bit LOW_RES     = 1'b0,
  parameter int DECIM       = 10
) (
  input  logic      clk,
  input  logic      rst,
  input  edgeStrb_t strb,
  output logic      outLvl,
  output logic      overrun
);
  localparam int LOAD  = DELAY_CYC - SYNC_STAGES;
  localparam int CNT_W = $clog2(DELAY_CYC + 1);
  localparam int TAPS  = DELAY_CYC / DECIM;
  localparam int PRE_W = $clog2(DECIM);

  wire unusedStrb = ^strb;

  generate
    if (LOW_RES == 1'b0) begin : g_fine
      logic riseAct, riseExp, riseRestart;
      logic fallAct, fallExp, fallRestart;

      edge_timer #(.LOAD(LOAD), .CNT_W(CNT_W)) uRise (
        .clk(clk), .rst(rst), .start(strb.riseStart),
        .active(riseAct), .expire(riseExp), .restart(riseRestart));

      edge_timer #(.LOAD(LOAD), .CNT_W(CNT_W)) uFall (
        .clk(clk), .rst(rst), .start(strb.fallStart),
        .active(fallAct), .expire(fallExp), .restart(fallRestart));

      always_ff @(posedge clk) begin
        if (rst) begin
          outLvl  <= 1'b0;
          overrun <= 1'b0;
        end else begin
          overrun <= riseRestart | fallRestart;
          if (fallExp)      outLvl <= 1'b0;
          else if (riseExp) outLvl <= 1'b1;
        end
      end

      AST_ONE_EXPIRE: assert property (@(posedge clk) disable iff (rst)
        !(riseExp && fallExp)); // R4
      AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strb.riseStart, strb.fallStart})); // R4
      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!riseAct && !fallAct) |=> $stable(outLvl)); // R5
      AST_RISE_FROM_TIMER: assert property (@(posedge clk) disable iff (rst)
        $rose(outLvl) |-> $past(riseAct)); // R2
      AST_OVR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        overrun |=> !overrun); // R6
    end else begin : g_coarse
      logic [PRE_W-1:0] pre;
      logic [TAPS-1:0]  taps;
      logic             tick;

      assign tick    = (pre == '0);
      assign outLvl  = taps[TAPS-1];
      assign overrun = 1'b0;

      always_ff @(posedge clk) begin
        if (rst) begin
          pre  <= '0;
          taps <= '0;
        end else begin
          pre <= (pre == PRE_W'(DECIM - 1)) ? '0 : pre + PRE_W'(1);
          if (tick) taps <= {taps[TAPS-2:0], strb.level};
        end
      end
    end
  endgenerate

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outLvl && !overrun)); // R1
endmodule

// File: rtl/edge_delay_line.sv
`timescale 1ns/1ps
module edge_delay_line
  import edge_delay_pkg::*;
#(
  parameter int DELAY_CYC   = 300,
  parameter int SYNC_STAGES = 2,
  parameter bit LOW_RES     = 1'b0,
  parameter int DECIM       = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic delayedOut,
  output logic overrun
);
  edgeStrb_t strb;

  edge_delay_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rst(rst), .asyncIn(asyncIn), .strb(strb));

  edge_delay_dp #(
    .DELAY_CYC(DELAY_CYC), .SYNC_STAGES(SYNC_STAGES),
    .LOW_RES(LOW_RES), .DECIM(DECIM)
  ) uDp (
    .clk(clk), .rst(rst), .strb(strb),
    .outLvl(delayedOut), .overrun(overrun));
endmodule

// File: tb/sim_edge_delay_line.sv
`timescale 1ns/1ps
module sim_edge_delay_line;
  localparam int D   = 300;
  localparam int S   = 2;
  localparam int DEC = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic out0, ovf0, out1, ovf1;

  always #2.5 clk = ~clk;

  edge_delay_line u0 (.clk(clk), .rst(rst), .asyncIn(din),
                      .delayedOut(out0), .overrun(ovf0));
  edge_delay_line #(.LOW_RES(1'b1), .DECIM(DEC)) u1 (
    .clk(clk), .rst(rst), .asyncIn(din), .delayedOut(out1), .overrun(ovf1));

  int   checks = 0, errors = 0, cyc = 0;
  logic hist [0:1023];
  bit   hiEn = 0, lrEn = 0;
  int   edgeQ [0:255];
  int   qWr = 0, qRd = 0;
  logic last1 = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  initial for (int i = 0; i < 1024; i++) hist[i] = 1'b0;

  // cycle counter and input history, sampled at the edge like the design
  always @(posedge clk) begin
    cyc = cyc + 1;
    hist[cyc % 1024] = din;
  end

  // model: output after edge n equals input sampled at edge n-D
  always @(negedge clk) begin
    if (hiEn) begin
      logic expV, prevV;
      expV  = hist[(cyc - D) % 1024];
      prevV = hist[(cyc - D - 1) % 1024];
      if (expV && !prevV)      chk(out0 == expV, "R2", out0, expV);
      else if (!expV && prevV) chk(out0 == expV, "R3", out0, expV);
      else                     chk(out0 == expV, "R5", out0, expV);
      chk(ovf0 == 1'b0, "R7", ovf0, 0);
    end
  end

  // coarse-mode instance: each output edge within one sample interval
  always @(negedge clk) begin
    if (out1 != last1) begin
      last1 = out1;
      if (lrEn) begin
        if (qRd == qWr) chk(1'b0, "R8", 0, 1);
        else begin
          int dl;
          dl = cyc - edgeQ[qRd % 256];
          qRd++;
          chk(dl >= D - DEC + S && dl <= D + S - 1, "R8", dl, D);
        end
        chk(ovf1 == 1'b0, "R8", ovf1, 0);
      end
    end
  end

  task automatic setLevel(input logic v);
    if (din !== v) begin
      din = v;
      edgeQ[qWr % 256] = cyc + 1;
      qWr++;
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int k1, k2, bad, hiCnt;
    void'($urandom(32'd20250517));
    waitCyc(5);
    chk(out0 == 1'b0 && ovf0 == 1'b0, "R1", {out0, ovf0}, 0);
    rst = 1'b0;

    // R1: pending rise discarded by reset
    setLevel(1'b1);
    waitCyc(100);
    rst = 1'b1;
    waitCyc(3);
    setLevel(1'b0);
    rst = 1'b0;
    bad = 0;
    for (int j = 0; j < D + 20; j++) begin
      waitCyc(1);
      if (out0 !== 1'b0 || ovf0 !== 1'b0) bad++;
    end
    chk(bad == 0, "R1", bad, 0);

    qWr = 0; qRd = 0; last1 = out1;
    hiEn = 1; lrEn = 1;

    // random phases, some shorter than the delay (R2, R3, R4, R5, R7, R8)
    for (int i = 0; i < 24; i++) begin
      setLevel(~din);
      waitCyc(160 + ($urandom % 260));
    end
    setLevel(1'b0);
    waitCyc(D + 40);
    lrEn = 0;

    // R4: short pulse kept with its width
    hiCnt = 0;
    setLevel(1'b1);
    for (int j = 0; j < 5; j++) begin waitCyc(1); if (out0) hiCnt++; end
    setLevel(1'b0);
    for (int j = 0; j < D + 40; j++) begin waitCyc(1); if (out0) hiCnt++; end
    chk(hiCnt == 5, "R4", hiCnt, 5);

    // R6: same-polarity edge while pending
    hiEn = 0;
    setLevel(1'b1);
    k1 = cyc + 1;
    waitCyc(5);
    setLevel(1'b0);
    waitCyc(45);
    setLevel(1'b1);
    k2 = cyc + 1;
    waitCyc(k2 + 1 - cyc);
    chk(ovf0 == 1'b0, "R6", ovf0, 0);
    waitCyc(1);
    chk(ovf0 == 1'b1, "R6", ovf0, 1);
    waitCyc(1);
    chk(ovf0 == 1'b0, "R6", ovf0, 0);
    waitCyc(k1 + D + 1 - cyc);
    chk(out0 == 1'b0, "R6", out0, 0);
    waitCyc(k2 + D - 1 - cyc);
    chk(out0 == 1'b0, "R6", out0, 0);
    waitCyc(1);
    chk(out0 == 1'b1, "R6", out0, 1);
    setLevel(1'b0);
    waitCyc(2 * D);
    hiEn = 1;
    waitCyc(D);
    finishRun();
  end
endmodule